// File: doc/BRIEF.md
# Event Timer Comparator Channel

One channel of a free-running event timer. The channel watches a shared main counter, compares it with a programmable comparator, and produces a single-cycle expiry pulse for the interrupt router. It has two modes. In one-shot mode it fires once when the counter reaches the comparator. In periodic mode it fires and then moves the comparator forward by a hidden period, so it keeps firing at a fixed spacing. A 32-bit mode limits comparison and arithmetic to the low half of the counter. In one-shot 32-bit operation, the channel also fires when the low half of the counter wraps before it reaches the comparator.

Software reaches the channel through a small word-wide register port with four words. Word 0 is the lower configuration word and word 1 is the read-only upper configuration word, which holds a bitmap of the allowed routes. Words 2 and 3 are the low and high halves of the comparator. Writes take effect at the next clock edge. Reads are combinational from the current word address. An input carries the global enable of the timer; no expiry occurs while it is low. The selected interrupt route is driven on an output for the router.

Top module: `tmr_channel`

## Requirements
- R1: After reset, word 0 reads 0x00000030, word 1 reads 0x00000C20, words 2 and 3 read 0xFFFFFFFF, `route_o` is 0 and `irq_o` is low.
- R2: A write to word 0 updates only bit 2 (interrupt enable), bit 3 (periodic), bit 6 (set-value), bit 8 (32-bit mode) and bits 13:9 (route). Bits 4 and 5 always read 1 and every other bit reads 0, so writing 0xFFFFFFFF reads back 0x00003F7C. Writes to word 1 are ignored.
- R3: `route_o` equals the value last written to bits 13:9 of word 0.
- R4: An armed one-shot channel with the global enable and the interrupt enable set raises `irq_o` for exactly one cycle. The pulse appears in the clock cycle after the edge at which `cnt_i` equals the comparator.
- R5: No pulse is produced while `glb_en_i` is low or while the interrupt enable bit is 0.
- R6: A write to word 2 or word 3 goes straight to the comparator half when the channel is in one-shot mode or when set-value is 1. Otherwise it goes to the matching half of the hidden period, and the period's top bit (bit 63, or bit 31 in 32-bit mode) is forced to 0. Any comparator write clears set-value.
- R7: In periodic mode, each expiry adds the period to the comparator. In 32-bit mode the addition is modulo 2^32.
- R8: Writing 1 to bit 8 clears the upper halves of the comparator and of the period. While 32-bit mode is set, matches compare only the low 32 bits, and writes to word 3 leave the comparator unchanged.
- R9: In one-shot 32-bit mode, arming with a comparator low half below the counter low half sets a pending wrap. The channel then pulses when the counter low half is 0xFFFFFFFF, and pulses again at the real match.
- R10: Raising `glb_en_i` arms the channel only if the comparator is not all ones. Any write to word 2 or word 3 arms the channel. An unarmed channel never pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_i | input | CNT_W | Shared main counter value |
| glb_en_i | input | 1 | Global timer enable |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word select (0 config low, 1 config high, 2 comparator low, 3 comparator high) |
| wdata_i | input | CNT_W/2 | Write data |
| rdata_o | output | CNT_W/2 | Read data for the word at `addr_i` |
| route_o | output | 5 | Selected interrupt route |
| irq_o | output | 1 | Single-cycle expiry pulse |

## Verification
The bench builds the channel with its default parameters: a 64-bit counter with 32-bit register words, the 0x00000C20 route bitmap, and a two-stage reset synchronizer. The counter is an input that the bench drives directly. The bench can therefore jump it to just below the 64-bit all-ones value and to just below the 32-bit wrap point. This puts the unarmed all-ones comparator, the modulo-2^32 periodic advance and the extra wrap pulse within a few dozen cycles, without running through the full count.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  // bit positions in the lower configuration word
  localparam int unsigned B_IE   = 2;
  localparam int unsigned B_PER  = 3;
  localparam int unsigned B_PCAP = 4;
  localparam int unsigned B_WCAP = 5;
  localparam int unsigned B_SETV = 6;
  localparam int unsigned B_M32  = 8;
  localparam int unsigned B_RT_LO = 9;
  localparam int unsigned RT_W   = 5;

  typedef enum logic [1:0] {
    A_CFG_LO = 2'd0,
    A_CFG_HI = 2'd1,
    A_CMP_LO = 2'd2,
    A_CMP_HI = 2'd3
  } word_e;

  typedef struct packed {
    logic [RT_W-1:0] route;
    logic            m32;
    logic            setv;
    logic            per;
    logic            ie;
  } cfg_t;
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
  import tmr_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  cfg_t wr_val_i,
  input  logic clr_setv_i,
  output cfg_t cfg_o
);
  cfg_t cfg_q, cfg_n;
  logic en;

  always_comb begin
    cfg_n = cfg_q;
    if (wr_i) cfg_n = wr_val_i;
    if (clr_setv_i) cfg_n.setv = 1'b0;
    en = wr_i | clr_setv_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (en) cfg_q <= cfg_n;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/tmr_cmp_store.sv
module tmr_cmp_store #(
  parameter int unsigned CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               per_i,
  input  logic               setv_i,
  input  logic               m32_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic               cut_hi_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  input  logic               adv_i,
  output logic [CNT_W-1:0]   cmp_o,
  output logic [CNT_W-1:0]   cmp_nxt_o
);
  localparam int unsigned H = CNT_W / 2;

  logic [CNT_W-1:0] cmp_q, cmp_n, per_q, per_n, pmask;
  logic [H-1:0]     sum_lo;
  logic             direct, en;

  always_comb begin
    pmask  = m32_i ? {{H{1'b0}}, 1'b0, {(H-1){1'b1}}} : {1'b0, {(CNT_W-1){1'b1}}};
    sum_lo = cmp_q[H-1:0] + per_q[H-1:0];
    direct = ~per_i | setv_i;
    cmp_n  = cmp_q;
    per_n  = per_q;
    if (adv_i) cmp_n = m32_i ? {{H{1'b0}}, sum_lo} : cmp_q + per_q;
    if (wr_lo_i) begin
      if (direct) cmp_n[H-1:0] = wdata_i;
      else        per_n[H-1:0] = wdata_i & pmask[H-1:0];
    end
    if (wr_hi_i && !m32_i) begin
      if (direct) cmp_n[CNT_W-1:H] = wdata_i;
      else        per_n[CNT_W-1:H] = wdata_i & pmask[CNT_W-1:H];
    end
    if (cut_hi_i) begin
      cmp_n[CNT_W-1:H] = '0;
      per_n[CNT_W-1:H] = '0;
    end
    en = adv_i | wr_lo_i | wr_hi_i | cut_hi_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      per_q <= '0;
    end else if (en) begin
      cmp_q <= cmp_n;
      per_q <= per_n;
    end
  end

  assign cmp_o     = cmp_q;
  assign cmp_nxt_o = cmp_n;
endmodule

// File: rtl/tmr_fire.sv
module tmr_fire #(
  parameter int unsigned CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               glb_en_i,
  input  logic               ie_i,
  input  logic               per_i,
  input  logic               m32_i,
  input  logic [CNT_W-1:0]   cmp_i,
  input  logic [CNT_W/2-1:0] cmp_nxt_lo_i,
  input  logic               cmp_wr_i,
  output logic               adv_o,
  output logic               armed_o,
  output logic               irq_o
);
  localparam int unsigned H = CNT_W / 2;

  logic glb_q, armed_q, wrap_q, irq_q;
  logic glb_n, armed_n, wrap_n, irq_n;
  logic hit, match_evt, wrap_evt, arm_evt;

  always_comb begin
    hit       = m32_i ? (cnt_i[H-1:0] == cmp_i[H-1:0]) : (cnt_i == cmp_i);
    match_evt = glb_en_i & armed_q & hit;
    wrap_evt  = glb_en_i & armed_q & wrap_q & m32_i & ~per_i & (&cnt_i[H-1:0]);
    arm_evt   = cmp_wr_i | (glb_en_i & ~glb_q & ~(&cmp_i));
    adv_o     = match_evt & per_i;
    glb_n     = glb_en_i;
    armed_n   = armed_q | arm_evt;
    wrap_n    = wrap_q;
    if (arm_evt)       wrap_n = m32_i & ~per_i & (cmp_nxt_lo_i < cnt_i[H-1:0]);
    else if (wrap_evt) wrap_n = 1'b0;
    irq_n     = ie_i & (match_evt | wrap_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q   <= 1'b0;
      armed_q <= 1'b0;
      wrap_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      glb_q   <= glb_n;
      armed_q <= armed_n;
      wrap_q  <= wrap_n;
      irq_q   <= irq_n;
    end
  end

  assign armed_o = armed_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_chan_pkg::*;
#(
  parameter int unsigned          CNT_W     = 64,
  parameter logic [CNT_W/2-1:0]   ROUTE_CAP = 32'h0000_0C20,
  parameter int unsigned          SYNC_N    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               glb_en_i,
  input  logic               wr_i,
  input  logic [1:0]         addr_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  output logic [CNT_W/2-1:0] rdata_o,
  output logic [RT_W-1:0]    route_o,
  output logic               irq_o
);
  localparam int unsigned DW = CNT_W / 2;

  // reset synchronizer: assert at once, release after SYNC_N edges
  logic [SYNC_N-1:0] sync_q, sync_n;
  logic              rst_s;

  always_comb sync_n = {sync_q[SYNC_N-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_n;
  end

  assign rst_s = sync_q[SYNC_N-1];

  // register port decode
  word_e wsel;
  logic  wr_cfg, wr_lo, wr_hi, cmp_wr, adv;
  cfg_t  cfg_q, cfg_wr;
  logic [CNT_W-1:0] cmp_w, cmp_nxt_w;
  logic  armed_w;

  always_comb begin
    wsel   = word_e'(addr_i);
    wr_cfg = wr_i & (wsel == A_CFG_LO);
    wr_lo  = wr_i & (wsel == A_CMP_LO);
    wr_hi  = wr_i & (wsel == A_CMP_HI);
    cmp_wr = wr_lo | wr_hi;
    cfg_wr.route = wdata_i[B_RT_LO +: RT_W];
    cfg_wr.m32   = wdata_i[B_M32];
    cfg_wr.setv  = wdata_i[B_SETV];
    cfg_wr.per   = wdata_i[B_PER];
    cfg_wr.ie    = wdata_i[B_IE];
  end

  tmr_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_s),
    .wr_i       (wr_cfg),
    .wr_val_i   (cfg_wr),
    .clr_setv_i (cmp_wr),
    .cfg_o      (cfg_q)
  );

  tmr_cmp_store #(.CNT_W(CNT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_s),
    .per_i     (cfg_q.per),
    .setv_i    (cfg_q.setv),
    .m32_i     (cfg_q.m32),
    .wr_lo_i   (wr_lo),
    .wr_hi_i   (wr_hi),
    .cut_hi_i  (wr_cfg & cfg_wr.m32),
    .wdata_i   (wdata_i),
    .adv_i     (adv),
    .cmp_o     (cmp_w),
    .cmp_nxt_o (cmp_nxt_w)
  );

  tmr_fire #(.CNT_W(CNT_W)) u_fire (
    .clk          (clk),
    .rst_n        (rst_s),
    .cnt_i        (cnt_i),
    .glb_en_i     (glb_en_i),
    .ie_i         (cfg_q.ie),
    .per_i        (cfg_q.per),
    .m32_i        (cfg_q.m32),
    .cmp_i        (cmp_w),
    .cmp_nxt_lo_i (cmp_nxt_w[DW-1:0]),
    .cmp_wr_i     (cmp_wr),
    .adv_o        (adv),
    .armed_o      (armed_w),
    .irq_o        (irq_o)
  );

  // read mux
  always_comb begin
    rdata_o = '0;
    unique case (wsel)
      A_CFG_LO: begin
        rdata_o[B_IE]   = cfg_q.ie;
        rdata_o[B_PER]  = cfg_q.per;
        rdata_o[B_PCAP] = 1'b1;
        rdata_o[B_WCAP] = 1'b1;
        rdata_o[B_SETV] = cfg_q.setv;
        rdata_o[B_M32]  = cfg_q.m32;
        rdata_o[B_RT_LO +: RT_W] = cfg_q.route;
      end
      A_CFG_HI: rdata_o = ROUTE_CAP;
      A_CMP_LO: rdata_o = cmp_w[DW-1:0];
      A_CMP_HI: rdata_o = cmp_w[CNT_W-1:DW];
      default:  rdata_o = '0;
    endcase
  end

  assign route_o = cfg_q.route;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input logic              clk,
  input logic              rst_s,
  input logic              wr_i,
  input logic [1:0]        addr_i,
  input logic [RT_W-1:0]   wroute_i,
  input logic              glb_en_i,
  input logic              ie_i,
  input logic              setv_i,
  input logic              m32_i,
  input logic              armed_i,
  input logic [CNT_W/2-1:0] cmp_hi_i,
  input logic [RT_W-1:0]   route_o,
  input logic              irq_o
);
  // R3: route output follows a configuration write
  p_route_follow_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_i && addr_i == 2'd0) |=> (route_o == $past(wroute_i)));

  // R5: a pulse needs the global and interrupt enables one cycle earlier
  p_pulse_gated_r5: assert property (@(posedge clk) disable iff (!rst_s)
    irq_o |-> ($past(glb_en_i) && $past(ie_i)));

  // R6: any comparator write leaves set-value cleared
  p_setv_cleared_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_i && addr_i[1]) |=> !setv_i);

  // R8: in 32-bit mode the comparator upper half stays zero
  p_hi_zero_r8: assert property (@(posedge clk) disable iff (!rst_s)
    m32_i |-> (cmp_hi_i == '0));

  // R10: an unarmed channel gives no pulse
  p_unarmed_quiet_r10: assert property (@(posedge clk) disable iff (!rst_s)
    !armed_i |=> !irq_o);
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wroute_i (wdata_i[13:9]),
  .glb_en_i (glb_en_i),
  .ie_i     (cfg_q.ie),
  .setv_i   (cfg_q.setv),
  .m32_i    (cfg_q.m32),
  .armed_i  (armed_w),
  .cmp_hi_i (cmp_w[CNT_W-1:CNT_W/2]),
  .route_o  (route_o),
  .irq_o    (irq_o)
);

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] cnt;
  logic        glb, wr;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata_o;
  logic [4:0]  route_o;
  logic        irq_o;

  always #5 clk = ~clk;

  tmr_channel i_tmr_channel (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .glb_en_i(glb), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .route_o(route_o), .irq_o(irq_o)
  );

  int    n_chk = 0, n_err = 0, pulses = 0;
  bit    run = 0, done = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [63:0] m_cmp, m_per;
  bit          m_ie, m_pm, m_setv, m_m32, m_armed, m_wrap, m_irq, m_glbq;
  logic [4:0]  m_rt;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return {18'b0, m_rt, m_m32, 1'b0, m_setv, 2'b11, m_pm, m_ie, 2'b00};
      2'd1: return 32'h0000_0C20;
      2'd2: return m_cmp[31:0];
      default: return m_cmp[63:32];
    endcase
  endfunction

  task automatic model_reset();
    m_cmp = '1; m_per = '0; m_ie = 0; m_pm = 0; m_setv = 0; m_m32 = 0;
    m_armed = 0; m_wrap = 0; m_irq = 0; m_glbq = 0; m_rt = '0;
  endtask

  task automatic model_step();
    bit hit, mev, wev, armev, direct;
    logic [63:0] c, p;
    hit = m_m32 ? (cnt[31:0] == m_cmp[31:0]) : (cnt == m_cmp);
    mev = glb && m_armed && hit;
    wev = glb && m_armed && m_wrap && m_m32 && !m_pm && (cnt[31:0] == 32'hFFFF_FFFF);
    c = m_cmp; p = m_per;
    if (mev && m_pm) c = m_m32 ? {32'h0, 32'(c[31:0] + p[31:0])} : c + p;
    direct = !m_pm || m_setv;
    if (wr && addr == 2'd2) begin
      if (direct) c[31:0] = wdata;
      else p[31:0] = m_m32 ? (wdata & 32'h7FFF_FFFF) : wdata;
    end
    if (wr && addr == 2'd3 && !m_m32) begin
      if (direct) c[63:32] = wdata;
      else p[63:32] = wdata & 32'h7FFF_FFFF;
    end
    armev = (wr && addr[1]) || (glb && !m_glbq && m_cmp != '1);
    m_irq = m_ie && (mev || wev);
    if (armev) m_wrap = m_m32 && !m_pm && (c[31:0] < cnt[31:0]);
    else if (wev) m_wrap = 0;
    if (armev) m_armed = 1;
    if (wr && addr == 2'd0) begin
      m_ie = wdata[2]; m_pm = wdata[3]; m_setv = wdata[6]; m_m32 = wdata[8]; m_rt = wdata[13:9];
      if (wdata[8]) begin c[63:32] = '0; p[63:32] = '0; end
    end
    if (wr && addr[1]) m_setv = 0;
    m_cmp = c; m_per = p; m_glbq = glb;
  endtask

  // one clock: model at the edge, compare at the falling edge, then move the counter
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(cur_req, "irq_o", {63'b0, irq_o}, {63'b0, m_irq});
    chk(cur_req, "route_o", {59'b0, route_o}, {59'b0, m_rt});
    chk(cur_req, "rdata_o", {32'b0, rdata_o}, {32'b0, exp_rd(addr)});
    if (irq_o) pulses++;
    if (run) cnt = cnt + 64'd1;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
    addr = a;
    tick();
    chk(req, "read", {32'b0, rdata_o}, {32'b0, exp});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr = 1'b0; glb = 1'b0; run = 1'b0; addr = 2'd0; wdata = '0; cnt = '0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog %s: actual=hung expected=finished", cur_req);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset values
    cur_req = "R1";
    do_reset();
    rd_chk("R1", 2'd0, 32'h0000_0030);
    rd_chk("R1", 2'd1, 32'h0000_0C20);
    rd_chk("R1", 2'd2, 32'hFFFF_FFFF);
    rd_chk("R1", 2'd3, 32'hFFFF_FFFF);
    chk("R1", "irq", {63'b0, irq_o}, 64'd0);

    // R2 R3 R8 R6: configuration mask, route, upper-half cut
    cur_req = "R2";
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_chk("R2", 2'd0, 32'h0000_3F7C);
    chk("R3", "route", {59'b0, route_o}, 64'h1F);
    cur_req = "R8";
    rd_chk("R8", 2'd3, 32'h0);
    wr_reg(2'd3, 32'h0000_0055);
    rd_chk("R8", 2'd3, 32'h0);
    cur_req = "R6";
    rd_chk("R6", 2'd0, 32'h0000_3F3C);
    cur_req = "R2";
    wr_reg(2'd1, 32'h1234_5678);
    rd_chk("R2", 2'd1, 32'h0000_0C20);
    wr_reg(2'd0, 32'h0000_0A00);
    rd_chk("R2", 2'd0, 32'h0000_0A30);
    chk("R3", "route", {59'b0, route_o}, 64'h05);

    // R10 all-ones comparator not armed, then R4 one-shot single pulse
    cur_req = "R10";
    do_reset();
    wr_reg(2'd0, 32'h4);
    cnt = 64'hFFFF_FFFF_FFFF_FFFD; glb = 1; run = 1; pulses = 0;
    repeat (8) tick();
    chk("R10", "pulses", pulses, 0);
    glb = 0; run = 0;
    cur_req = "R4";
    wr_reg(2'd2, 32'd110);
    wr_reg(2'd3, 32'd0);
    cnt = 64'd100; glb = 1; run = 1; pulses = 0;
    repeat (20) tick();
    chk("R4", "pulses", pulses, 1);
    glb = 0; run = 0;

    // R5 interrupt enable low, then global enable low
    cur_req = "R5";
    do_reset();
    wr_reg(2'd2, 32'd205);
    wr_reg(2'd3, 32'd0);
    cnt = 64'd200; glb = 1; run = 1; pulses = 0;
    repeat (15) tick();
    chk("R5", "pulses ie=0", pulses, 0);
    glb = 0; run = 0;
    wr_reg(2'd0, 32'h4);
    wr_reg(2'd2, 32'd305);
    cnt = 64'd300; run = 1; pulses = 0;
    repeat (15) tick();
    chk("R5", "pulses glb=0", pulses, 0);
    run = 0;

    // R6 period routing, R7 periodic advance
    cur_req = "R6";
    do_reset();
    wr_reg(2'd0, 32'h44);
    wr_reg(2'd2, 32'd50);
    wr_reg(2'd3, 32'd0);
    wr_reg(2'd0, 32'h0C);
    wr_reg(2'd2, 32'd20);
    rd_chk("R6", 2'd2, 32'd50);
    cur_req = "R7";
    cnt = 64'd40; glb = 1; run = 1; pulses = 0;
    repeat (80) tick();
    glb = 0; run = 0;
    chk("R7", "pulses", pulses, 4);
    rd_chk("R7", 2'd2, 32'd130);
    cur_req = "R6";
    wr_reg(2'd3, 32'hFFFF_FFFF);
    rd_chk("R6", 2'd3, 32'h0);
    cnt = 64'd130; glb = 1;
    tick();
    glb = 0;
    tick();
    rd_chk("R6", 2'd3, 32'h7FFF_FFFF);
    rd_chk("R7", 2'd2, 32'h0000_0096);

    // R8 32-bit periodic with modulo advance
    cur_req = "R8";
    do_reset();
    wr_reg(2'd0, 32'h14C);
    wr_reg(2'd2, 32'hFFFF_FFF0);
    wr_reg(2'd2, 32'h20);
    cnt = 64'h0000_0005_FFFF_FFE0; glb = 1; run = 1; pulses = 0;
    repeat (60) tick();
    glb = 0; run = 0;
    chk("R8", "pulses", pulses, 2);
    rd_chk("R7", 2'd2, 32'h30);
    rd_chk("R8", 2'd3, 32'h0);

    // R9 one-shot 32-bit wrap pulse plus real match
    cur_req = "R9";
    do_reset();
    wr_reg(2'd0, 32'h104);
    cnt = 64'hFFFF_FFF0;
    wr_reg(2'd2, 32'h8);
    glb = 1; run = 1; pulses = 0;
    repeat (30) tick();
    glb = 0; run = 0;
    chk("R9", "pulses with wrap", pulses, 2);
    cnt = 64'h10;
    wr_reg(2'd2, 32'h20);
    glb = 1; run = 1; pulses = 0;
    repeat (40) tick();
    glb = 0; run = 0;
    chk("R9", "pulses without wrap", pulses, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule